// File: doc/BRIEF.md
# Power-On Reset and Watchdog Reset Generator

This block produces the single active-low reset that holds the processor core. It recognises three causes of reset. The first is power arriving: the raw power-good input rises and a fixed delay follows. The second is a watchdog expiry: a retriggerable one-shot, clocked by the system clock, runs out because software stopped refreshing it. The third is a wake from stop mode: a recovery input is held long enough. Power-good acts as the block's synchronous active-low reset, and the block assumes the signal is already aligned to the clock.

The watchdog runs by itself once the core leaves reset, but only when the mask-option strap enables it. A refresh strobe from the instruction decoder restarts its count. After the last reset, two flags tell software which kind it was. The hot flag marks a watchdog expiry, and only loss of power clears it. The stop flag marks a wake from stop mode, and a watchdog expiry or loss of power clears it. Watchdog and wake resets each hold the core for a fixed pulse of `RST_PULSE` clocks.

Top module: `rst_cause_gen`

## Requirements
- R1: While `pwr_ok` is low, `core_rst_n`, `hot_flag` and `stop_flag` are all 0 from the next clock edge on.
- R2: After `pwr_ok` rises, `core_rst_n` stays 0 for `POR_CYCLES` clock edges and reads 1 after the edge that follows them.
- R3: With `wdt_opt_en` at 1 and no refresh, `core_rst_n` falls exactly `WDT_CYCLES` edges after the edge that released it.
- R4: A refresh strobe (`wdt_kick` = 1 at an edge) restarts the count, so the next expiry comes `WDT_CYCLES` edges after that edge.
- R5: With `wdt_opt_en` at 0 the watchdog never expires, and `wdt_kick` has no effect.
- R6: A watchdog or wake reset holds `core_rst_n` at 0 for exactly `RST_PULSE` cycles. The core is then released without a new power-on delay, and the watchdog restarts from zero.
- R7: `hot_flag` becomes 1 at the same edge on which a watchdog reset begins. Wake resets do not change it, and only `pwr_ok` low clears it.
- R8: `stop_flag` becomes 1 at the edge on which a wake reset begins, and a watchdog reset clears it to 0.
- R9: A wake reset fires on the `STOP_MIN`-th consecutive edge that samples `stop_wake` at 1. A shorter hold has no effect, and a longer hold fires only once until `stop_wake` has returned to 0.
- R10: When a watchdog expiry and a qualified wake fall on the same edge, the watchdog cause wins: `hot_flag` = 1 and `stop_flag` = 0.
- R11: Samples of `stop_wake` taken while `core_rst_n` is 0 do not count toward the `STOP_MIN` hold. Counting starts with the first edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_ok | input | 1 | Raw power-good, synchronous; low resets the whole block |
| wdt_kick | input | 1 | Watchdog refresh strobe from the instruction decoder |
| wdt_opt_en | input | 1 | Mask-option strap that enables the watchdog |
| stop_wake | input | 1 | Stop-mode recovery request level |
| core_rst_n | output | 1 | Active-low reset to the core, registered |
| hot_flag | output | 1 | 1 after a watchdog-caused reset |
| stop_flag | output | 1 | 1 after a stop-mode recovery reset |

## Verification
Every result in this block is tied to a whole number of clock edges after its stimulus. Release after power-up comes on edge `POR_CYCLES`+1. A watchdog reset comes `WDT_CYCLES` edges after release or after the last refresh edge. A wake reset comes on the `STOP_MIN`-th high sample. Release after a pulse comes `RST_PULSE` edges after it began. The flags change on the same edge as the reset falls. The bench drives inputs on the falling edge and steps a counted number of edges. It samples one edge before and one edge after each due edge, so a result that is early or late by a single cycle is caught. A monitor counts falling edges of the reset, which shows the cases where a stimulus must cause nothing.

// File: rtl/rcg_pkg.sv
// Shared types for the reset-cause generator.
package rcg_pkg;
    // Which cause, if any, starts a reset pulse on this edge.
    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_WDOG = 2'd1,
        TRIG_WAKE = 2'd2
    } trig_e;
endpackage

// File: rtl/rcg_por_delay.sv
// Power-up delay counter.
// Counts clock edges once pwr_ok is high and reports when POR_CYCLES have passed.
// Assumes pwr_ok is synchronous to clk. The count saturates, so it runs only once per power-up.
module rcg_por_delay #(
    parameter int unsigned POR_CYCLES = 590000
) (
    input  logic clk,
    input  logic pwr_ok,
    output logic por_done
);
    localparam int unsigned CW = $clog2(POR_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Count up from power-good to the delay length and hold there.
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            cnt <= '0;
        end else if (cnt != CW'(POR_CYCLES)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign por_done = (cnt == CW'(POR_CYCLES));
endmodule

// File: rtl/rcg_wdog.sv
// Retriggerable watchdog one-shot.
// Counts while run is high and raises expire on the WDT_CYCLES-th edge with no refresh.
// Assumes run drops right after expire, because the core then enters reset. That drop clears the count.
module rcg_wdog #(
    parameter int unsigned WDT_CYCLES = 265000
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int unsigned CW   = (WDT_CYCLES > 1) ? $clog2(WDT_CYCLES) : 1;
    localparam int unsigned LAST = WDT_CYCLES - 1;

    logic [CW-1:0] cnt;

    // Restart on refresh or while stopped, otherwise advance toward terminal count.
    always_ff @(posedge clk) begin
        if (!pwr_ok || !run || kick) begin
            cnt <= '0;
        end else if (cnt != CW'(LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && !kick && (cnt == CW'(LAST));
endmodule

// File: rtl/rcg_wake_qual.sv
// Stop-mode recovery qualifier.
// Fires once when wake has been sampled high on STOP_MIN consecutive edges while the core runs.
// Assumes active is the registered core reset release. The qualifier re-arms only after wake goes low.
module rcg_wake_qual #(
    parameter int unsigned STOP_MIN = 5
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic active,
    input  logic wake,
    output logic fire
);
    localparam int unsigned CW = $clog2(STOP_MIN + 1);

    logic [CW-1:0] cnt;
    logic          armed;

    assign fire = active && wake && armed && (cnt == CW'(STOP_MIN - 1));

    // Track the high-run length of wake and the one-shot arming.
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else begin
            if (!wake) begin
                armed <= 1'b1;
            end else if (fire) begin
                armed <= 1'b0;
            end
            if (!active || !wake || !armed || fire) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rcg_stretch.sv
// Reset pulse stretcher and registered reset output.
// Holds rst_n low until the power-up delay is done. Each trig also holds it low for exactly RST_PULSE cycles.
// Assumes trig arrives only while rst_n is high. RST_PULSE must be at least 1.
module rcg_stretch #(
    parameter int unsigned RST_PULSE = 16
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic por_done,
    input  logic trig,
    output logic rst_n
);
    localparam int unsigned CW = $clog2(RST_PULSE + 1);

    logic [CW-1:0] left;

    // Load the pulse length on a trigger, then count it down.
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            left <= '0;
        end else if (trig) begin
            left <= CW'(RST_PULSE);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    // Release the core only after power-up and once the pulse has drained.
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            rst_n <= 1'b0;
        end else begin
            rst_n <= por_done && !trig && (left <= CW'(1));
        end
    end
endmodule

// File: rtl/rst_cause_gen.sv
// Reset generator with power-up delay, watchdog and stop-mode recovery, plus cause flags.
// Assumes pwr_ok is synchronous and wdt_opt_en is a static strap.
// hot_flag survives every reset except power loss. stop_flag is cleared by a watchdog reset.
module rst_cause_gen #(
    parameter int unsigned POR_CYCLES = 590000,
    parameter int unsigned WDT_CYCLES = 265000,
    parameter int unsigned RST_PULSE  = 16,
    parameter int unsigned STOP_MIN   = 5
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic wdt_kick,
    input  logic wdt_opt_en,
    input  logic stop_wake,
    output logic core_rst_n,
    output logic hot_flag,
    output logic stop_flag
);
    import rcg_pkg::*;

    logic  por_done;
    logic  wd_expire;
    logic  wake_fire;
    trig_e trig;

    rcg_por_delay #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk      (clk),
        .pwr_ok   (pwr_ok),
        .por_done (por_done)
    );

    rcg_wdog #(.WDT_CYCLES(WDT_CYCLES)) u_wdog (
        .clk    (clk),
        .pwr_ok (pwr_ok),
        .run    (core_rst_n && wdt_opt_en),
        .kick   (wdt_kick),
        .expire (wd_expire)
    );

    rcg_wake_qual #(.STOP_MIN(STOP_MIN)) u_wake (
        .clk    (clk),
        .pwr_ok (pwr_ok),
        .active (core_rst_n),
        .wake   (stop_wake),
        .fire   (wake_fire)
    );

    // Pick the cause for this edge; the watchdog outranks a wake.
    always_comb begin
        if (wd_expire) begin
            trig = TRIG_WDOG;
        end else if (wake_fire) begin
            trig = TRIG_WAKE;
        end else begin
            trig = TRIG_NONE;
        end
    end

    rcg_stretch #(.RST_PULSE(RST_PULSE)) u_stretch (
        .clk      (clk),
        .pwr_ok   (pwr_ok),
        .por_done (por_done),
        .trig     (trig != TRIG_NONE),
        .rst_n    (core_rst_n)
    );

    // Record the cause of the reset that starts on this edge.
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            hot_flag  <= 1'b0;
            stop_flag <= 1'b0;
        end else begin
            case (trig)
                TRIG_WDOG: begin
                    hot_flag  <= 1'b1;
                    stop_flag <= 1'b0;
                end
                TRIG_WAKE: stop_flag <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rst_cause_gen_chk.sv
// Property checker for rst_cause_gen, bound into every instance.
// Watches only the top-level ports. Pulse length is measured with a local counter.
module rst_cause_gen_chk #(
    parameter int unsigned RST_PULSE = 16
) (
    input logic clk,
    input logic pwr_ok,
    input logic wdt_kick,
    input logic wdt_opt_en,
    input logic stop_wake,
    input logic core_rst_n,
    input logic hot_flag,
    input logic stop_flag
);
    localparam int unsigned LW = $clog2(RST_PULSE + 2);

    logic [LW-1:0] low_cnt;
    logic          seen_run;

    // Measure the current low run of the core reset, saturating above the pulse length.
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            low_cnt  <= '0;
            seen_run <= 1'b0;
        end else begin
            if (core_rst_n) begin
                low_cnt  <= '0;
                seen_run <= 1'b1;
            end else if (low_cnt != LW'(RST_PULSE + 1)) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    p_kick_holds_r4: assert property (@(posedge clk) disable iff (!pwr_ok)
        (wdt_kick && core_rst_n && !stop_wake) |=> core_rst_n);

    p_opt_off_r5: assert property (@(posedge clk) disable iff (!pwr_ok)
        (!wdt_opt_en && core_rst_n && !stop_wake) |=> core_rst_n);

    p_pulse_len_r6: assert property (@(posedge clk) disable iff (!pwr_ok)
        ($rose(core_rst_n) && seen_run) |-> (low_cnt == LW'(RST_PULSE)));

    p_hot_sticky_r7: assert property (@(posedge clk) disable iff (!pwr_ok)
        !$fell(hot_flag));

    p_hot_with_reset_r7: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(hot_flag) |-> $fell(core_rst_n));

    p_stop_with_reset_r8: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(stop_flag) |-> $fell(core_rst_n));

    p_wdog_wins_r10: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(hot_flag) |-> !stop_flag);
endmodule

bind rst_cause_gen rst_cause_gen_chk #(.RST_PULSE(RST_PULSE)) u_chk (
    .clk        (clk),
    .pwr_ok     (pwr_ok),
    .wdt_kick   (wdt_kick),
    .wdt_opt_en (wdt_opt_en),
    .stop_wake  (stop_wake),
    .core_rst_n (core_rst_n),
    .hot_flag   (hot_flag),
    .stop_flag  (stop_flag)
);

// File: tb/rst_cause_gen_tb.sv
module rst_cause_gen_tb;
    localparam int unsigned POR_C  = 20;
    localparam int unsigned WDT_C  = 40;
    localparam int unsigned PULSE  = 16;
    localparam int unsigned SMIN   = 5;
    localparam int          NVEC   = 6;
    // Wake-hold table: hold length, expected reset falls, expected stop flag afterwards.
    localparam int unsigned HOLD_TAB [NVEC] = '{1, 4, 5, 3, 30, 6};
    localparam int unsigned FALL_TAB [NVEC] = '{0, 0, 1, 0, 1, 1};
    localparam int unsigned STOP_TAB [NVEC] = '{0, 0, 1, 1, 1, 1};

    logic clk = 1'b0;
    logic pwr_ok = 1'b0;
    logic wdt_kick = 1'b0;
    logic wdt_opt_en = 1'b1;
    logic stop_wake = 1'b0;
    logic core_rst_n, hot_flag, stop_flag;

    int total = 0;
    int fails = 0;
    int falls = 0;
    logic prev_rst = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rst_cause_gen #(
        .POR_CYCLES (POR_C),
        .WDT_CYCLES (WDT_C),
        .RST_PULSE  (PULSE),
        .STOP_MIN   (SMIN)
    ) u_dut (
        .clk        (clk),
        .pwr_ok     (pwr_ok),
        .wdt_kick   (wdt_kick),
        .wdt_opt_en (wdt_opt_en),
        .stop_wake  (stop_wake),
        .core_rst_n (core_rst_n),
        .hot_flag   (hot_flag),
        .stop_flag  (stop_flag)
    );

    // Count falling edges of the core reset, just after each clock edge.
    always @(posedge clk) begin
        #1;
        if (prev_rst === 1'b1 && core_rst_n === 1'b0) falls++;
        prev_rst = core_rst_n;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1: state held while power is absent
        step(5);
        chk("R1 rst low", core_rst_n, 0);
        chk("R1 hot clear", hot_flag, 0);
        chk("R1 stop clear", stop_flag, 0);

        // R2: power-up delay
        pwr_ok = 1'b1;
        step(POR_C);
        chk("R2 still in reset", core_rst_n, 0);
        step(1);
        chk("R2 released", core_rst_n, 1);

        // R3 / R7 / R8: unrefreshed watchdog expiry
        step(WDT_C - 1);
        chk("R3 before expiry", core_rst_n, 1);
        step(1);
        chk("R3 expiry reset", core_rst_n, 0);
        chk("R7 hot set", hot_flag, 1);
        chk("R8 stop clear on wdog", stop_flag, 0);

        // R6: pulse length
        step(PULSE - 1);
        chk("R6 pulse held", core_rst_n, 0);
        step(1);
        chk("R6 pulse ends", core_rst_n, 1);

        // R4: refresh restarts the count
        step(30);
        wdt_kick = 1'b1;
        step(1);
        wdt_kick = 1'b0;
        step(WDT_C - 1);
        chk("R4 refresh delays expiry", core_rst_n, 1);
        step(1);
        chk("R4 expiry after refresh", core_rst_n, 0);
        step(PULSE);
        chk("R6 released again", core_rst_n, 1);
        chk("R7 hot kept across pulse", hot_flag, 1);

        // R5: watchdog disabled by strap, refresh ignored
        wdt_opt_en = 1'b0;
        falls = 0;
        step(30);
        wdt_kick = 1'b1;
        step(1);
        wdt_kick = 1'b0;
        step(70);
        chk("R5 no expiry when disabled", falls, 0);
        chk("R5 core still running", core_rst_n, 1);

        // R9 / R8: table of wake hold lengths
        for (int i = 0; i < NVEC; i++) begin
            falls = 0;
            stop_wake = 1'b1;
            step(HOLD_TAB[i]);
            stop_wake = 1'b0;
            step(25);
            chk($sformatf("R9 wake hold %0d falls", HOLD_TAB[i]), falls, FALL_TAB[i]);
            chk($sformatf("R8 wake hold %0d stop", HOLD_TAB[i]), stop_flag, STOP_TAB[i]);
            chk($sformatf("R9 wake hold %0d running", HOLD_TAB[i]), core_rst_n, 1);
        end
        chk("R7 hot unchanged by wake", hot_flag, 1);

        // R10: expiry and wake on the same edge
        wdt_opt_en = 1'b1;
        wdt_kick = 1'b1;
        step(1);
        wdt_kick = 1'b0;
        step(WDT_C - SMIN);
        stop_wake = 1'b1;
        step(SMIN);
        chk("R10 reset on tie", core_rst_n, 0);
        chk("R10 hot on tie", hot_flag, 1);
        chk("R10 stop cleared on tie", stop_flag, 0);
        stop_wake = 1'b0;
        step(PULSE);
        chk("R6 release after tie", core_rst_n, 1);

        // R1 / R11: power loss, then wake held through the power-up delay
        wdt_opt_en = 1'b0;
        pwr_ok = 1'b0;
        stop_wake = 1'b1;
        step(3);
        chk("R1 hot cleared by power loss", hot_flag, 0);
        chk("R1 stop cleared by power loss", stop_flag, 0);
        chk("R1 rst low on power loss", core_rst_n, 0);
        pwr_ok = 1'b1;
        step(POR_C + 1);
        chk("R11 released despite wake", core_rst_n, 1);
        step(SMIN - 1);
        chk("R11 wake not yet qualified", core_rst_n, 1);
        step(1);
        chk("R11 wake counted from release", core_rst_n, 0);
        chk("R11 stop set", stop_flag, 1);
        stop_wake = 1'b0;
        step(PULSE);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule